// File: doc/BRIEF.md
# Supply Changeover and Host Access Gate

This block is the digital half of a timekeeping device's power monitor. Two analog comparators report, without any relation to the core clock, whether the main supply has dropped under the power-fail threshold and whether it has dropped under the backup cell voltage. The block decides from these two results which rail powers the device and whether the host may touch the timekeeping registers. While the host is locked out, a bus transaction already in flight is aborted and its write is dropped.

When the main supply comes back, host access is withheld for a recovery interval. The interval is counted in ticks of the 32.768 kHz reference, with a default of 66 ticks, which is about 2 ms. The interval applies only while the oscillator runs. With the oscillator stopped, access returns as soon as the supply is good. A new dip during the interval starts it over. Timekeeping itself is not gated: the block only selects the rail, so the counters keep running from the backup cell.

The controller is a four-state machine:
- `ST_ONLINE`: main supply good, host access open.
- `ST_HOLD`: main supply under the threshold but above the cell, so the main rail stays selected and access is closed.
- `ST_BACKUP`: main supply under both levels, so the backup rail is selected and access is closed.
- `ST_RECOVER`: supply good again and the interval is being counted.

Transitions:
- DIP: `ST_ONLINE` goes to `ST_HOLD` or `ST_BACKUP`, whichever matches the second comparator.
- SWAP: `ST_HOLD` and `ST_BACKUP` move between each other as the second comparator changes.
- RISE_OSC: `ST_HOLD` or `ST_BACKUP` goes to `ST_RECOVER` when the supply is good and the oscillator runs.
- RISE_NOOSC: `ST_HOLD` or `ST_BACKUP` goes to `ST_ONLINE` when the supply is good and the oscillator is stopped.
- REDIP: `ST_RECOVER` goes back to `ST_HOLD` or `ST_BACKUP`.
- EXPIRE: `ST_RECOVER` goes to `ST_ONLINE` when the count completes.
- OSC_LOST: `ST_RECOVER` goes to `ST_ONLINE` when the oscillator stops.

Reset places the machine in `ST_HOLD`. The synchronizers reset to "under threshold, above cell".

Top module: `pwr_seq_top`

## Requirements
- R1: `access_en` is 0 and `bus_block` is 1 in every state except `ST_ONLINE`. Access reopens only after the synchronized power-fail comparator has reported a good supply.
- R2: `sel_backup` is 1 only when both synchronized comparators report low (main supply under the threshold and under the cell). Otherwise it is 0 and the main rail is used.
- R3: With the main supply under the threshold but above the cell, `sel_backup` is 0 and `access_en` is 0.
- R4: After the supply becomes good with `osc_on` = 1, `access_en` stays 0 until `REC_TICKS` rising `ref_tick` cycles have been counted in `ST_RECOVER`. It becomes 1 one clock later.
- R5: If `osc_on` is 0 when the supply becomes good, or drops to 0 during recovery, `access_en` becomes 1 on the next state update, with no wait for ticks.
- R6: A power-fail indication during `ST_RECOVER` closes access and discards the partial count. The full interval restarts on the next recovery.
- R7: `bus_abort` is 1 whenever `bus_busy` = 1 while access is closed. `wr_commit` is 1 only for `bus_wr` = 1 while access is open. A write issued while access is closed is dropped.
- R8: During and directly after reset: `access_en` = 0, `bus_block` = 1, `sel_backup` = 0.
- R9: Each comparator input passes two synchronizer flops. A change applied before clock edge n changes the outputs at edge n+2 and not earlier.
- R10: The cell comparator alone (main supply above the threshold) neither selects the backup rail nor closes access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-clock pulse per 32.768 kHz reference period |
| vcc_lt_pf_a | input | 1 | Asynchronous comparator: main supply under the power-fail threshold |
| vcc_lt_bkp_a | input | 1 | Asynchronous comparator: main supply under the backup cell |
| osc_on | input | 1 | Oscillator running (synchronous) |
| bus_busy | input | 1 | Host transaction in progress |
| bus_wr | input | 1 | Host write strobe |
| sel_backup | output | 1 | 1 selects the backup rail |
| access_en | output | 1 | Host register access allowed |
| bus_block | output | 1 | Host transactions refused |
| bus_abort | output | 1 | Abort the running host transaction |
| wr_commit | output | 1 | Forward the host write to the registers |

## Verification
A supply dip can coincide with the last tick of the recovery count. The bench provokes this by dropping the power-fail comparator during a recovery window, and the cycle-by-cycle reference model judges which outcome wins: the dip wins. The same holds when the oscillator stops in the cycle the supply recovers. The bench clears `osc_on` while the synchronized comparator is still changing and checks that access reopens with no tick wait. An abort can also fall in the cycle access closes, so the bench holds `bus_busy` and `bus_wr` across the transition and compares `bus_abort` and `wr_commit` on every clock.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        ST_ONLINE  = 2'd0,
        ST_HOLD    = 2'd1,
        ST_BACKUP  = 2'd2,
        ST_RECOVER = 2'd3
    } pwr_state_t;

    // reset values of the synchronizer flops: "below threshold, above cell"
    localparam logic SYNC_RST_PF  = 1'b1;
    localparam logic SYNC_RST_BKP = 1'b0;

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pwr_rec_timer.sv
module pwr_rec_timer #(
    parameter int REC_TICKS = 66
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(REC_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(REC_TICKS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt <= '0;
        else if (!run)                  cnt <= '0;
        else if (tick && cnt != LIMIT)  cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LIMIT);
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pf_low,
    input  logic bkp_low,
    input  logic osc_on,
    input  logic rec_done,
    output logic sel_backup,
    output logic access_en,
    output logic run_timer
);
    pwr_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ONLINE: begin
                if (pf_low) state_nx = bkp_low ? ST_BACKUP : ST_HOLD;   // DIP
            end
            ST_HOLD, ST_BACKUP: begin
                if (pf_low)      state_nx = bkp_low ? ST_BACKUP : ST_HOLD; // SWAP
                else if (osc_on) state_nx = ST_RECOVER;                    // RISE_OSC
                else             state_nx = ST_ONLINE;                     // RISE_NOOSC
            end
            ST_RECOVER: begin
                if (pf_low)        state_nx = bkp_low ? ST_BACKUP : ST_HOLD; // REDIP
                else if (!osc_on)  state_nx = ST_ONLINE;                     // OSC_LOST
                else if (rec_done) state_nx = ST_ONLINE;                     // EXPIRE
            end
            default: state_nx = ST_HOLD;
        endcase
    end

    always_comb begin
        sel_backup = 1'b0;
        access_en  = 1'b0;
        run_timer  = 1'b0;
        unique case (state)
            ST_ONLINE:  access_en  = 1'b1;
            ST_HOLD:    ;
            ST_BACKUP:  sel_backup = 1'b1;
            ST_RECOVER: run_timer  = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int REC_TICKS   = 66,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic vcc_lt_pf_a,
    input  logic vcc_lt_bkp_a,
    input  logic osc_on,
    input  logic bus_busy,
    input  logic bus_wr,
    output logic sel_backup,
    output logic access_en,
    output logic bus_block,
    output logic bus_abort,
    output logic wr_commit
);
    logic pf_low_s;
    logic bkp_low_s;
    logic run_timer;
    logic rec_done;

    pwr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST_PF)) u_sync_pf (
        .clk(clk), .rst_n(rst_n), .d_async(vcc_lt_pf_a), .q_sync(pf_low_s));

    pwr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST_BKP)) u_sync_bkp (
        .clk(clk), .rst_n(rst_n), .d_async(vcc_lt_bkp_a), .q_sync(bkp_low_s));

    pwr_rec_timer #(.REC_TICKS(REC_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run_timer), .tick(ref_tick), .done(rec_done));

    pwr_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .pf_low(pf_low_s), .bkp_low(bkp_low_s), .osc_on(osc_on),
        .rec_done(rec_done),
        .sel_backup(sel_backup), .access_en(access_en), .run_timer(run_timer));

    assign bus_block = !access_en;
    assign bus_abort = bus_busy && !access_en;
    assign wr_commit = bus_wr && access_en;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic pf_low_s,
    input logic bkp_low_s,
    input logic osc_on,
    input logic bus_busy,
    input logic sel_backup,
    input logic access_en,
    input logic bus_abort
);
    // R1
    open_after_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_en) |-> !$past(pf_low_s));

    // R3
    hold_on_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pf_low_s && !bkp_low_s) |-> (!sel_backup && !access_en));

    // R2
    backup_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_backup) |-> $past(pf_low_s && bkp_low_s));

    // R5
    no_osc_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!pf_low_s && !osc_on) |-> access_en);

    // R7
    abort_on_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(access_en) && bus_busy) |-> bus_abort);
endmodule

bind pwr_seq_top pwr_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pf_low_s(pf_low_s), .bkp_low_s(bkp_low_s),
    .osc_on(osc_on), .bus_busy(bus_busy), .sel_backup(sel_backup),
    .access_en(access_en), .bus_abort(bus_abort));

// File: tb/sim_pwr_seq_top.sv
`timescale 1ns/1ps
module sim_pwr_seq_top;
    localparam int REC = 66;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_tick = 1'b0;
    logic pf_a = 1'b0, bkp_a = 1'b0, osc = 1'b1, busy = 1'b0, wr = 1'b0;
    logic sel_backup, access_en, bus_block, bus_abort, wr_commit;

    int checks = 0, errors = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    pwr_seq_top #(.REC_TICKS(REC)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .vcc_lt_pf_a(pf_a), .vcc_lt_bkp_a(bkp_a), .osc_on(osc),
        .bus_busy(busy), .bus_wr(wr),
        .sel_backup(sel_backup), .access_en(access_en), .bus_block(bus_block),
        .bus_abort(bus_abort), .wr_commit(wr_commit));

    // reference tick: one clock in four
    int div = 0;
    always @(negedge clk) begin
        div      <= (div + 1) % 4;
        ref_tick <= (div == 3);
    end

    // behavioural reference: 0 online, 1 hold, 2 backup, 3 recover
    logic q_pf[$], q_bkp[$];
    int m_st, m_cnt;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_pf = {1'b1, 1'b1}; q_bkp = {1'b0, 1'b0};
            m_st = 1; m_cnt = 0;
        end else begin
            logic sp, sb;
            int nst, ncnt;
            sp = q_pf[0]; sb = q_bkp[0];
            nst = m_st;
            if (sp)                          nst = sb ? 2 : 1;
            else if (m_st == 1 || m_st == 2) nst = osc ? 3 : 0;
            else if (m_st == 3 && (!osc || m_cnt == REC)) nst = 0;
            ncnt = (m_st != 3) ? 0 : ((ref_tick && m_cnt < REC) ? m_cnt + 1 : m_cnt);
            m_st = nst; m_cnt = ncnt;
            void'(q_pf.pop_front());  q_pf.push_back(pf_a);
            void'(q_bkp.pop_front()); q_bkp.push_back(bkp_a);
        end
    end

    task automatic expect1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (rst_n && !done_flag) begin
            expect1("R1 access_en vs model", access_en, m_st == 0);
            expect1("R1 bus_block vs model", bus_block, m_st != 0);
            expect1("R2 sel_backup vs model", sel_backup, m_st == 2);
            expect1("R7 bus_abort vs model", bus_abort, busy && (m_st != 0));
            expect1("R7 wr_commit vs model", wr_commit, wr && (m_st == 0));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic ticks(input int n);
        int k = 0;
        while (k < n) begin
            @(negedge clk);
            if (ref_tick) k++;
        end
        #2;
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        // R8 reset state
        expect1("R8 access_en in reset", access_en, 1'b0);
        expect1("R8 bus_block in reset", bus_block, 1'b1);
        expect1("R8 sel_backup in reset", sel_backup, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        cyc(1);
        expect1("R8 access_en after reset", access_en, 1'b0);
        // R4 power-up recovery with oscillator running
        ticks(60);
        expect1("R4 still closed at 60 ticks", access_en, 1'b0);
        ticks(10);
        expect1("R4 open after interval", access_en, 1'b1);

        // R10 cell comparator alone
        bkp_a = 1'b1; cyc(6);
        expect1("R10 access kept", access_en, 1'b1);
        expect1("R10 no backup", sel_backup, 1'b0);
        bkp_a = 1'b0;

        // R7 write while open
        wr = 1'b1; busy = 1'b1; cyc(1);
        expect1("R7 commit while open", wr_commit, 1'b1);

        // R9 latency, R3 hold on main (bus kept busy across close)
        pf_a = 1'b1;
        cyc(2);
        expect1("R9 unchanged after two edges", access_en, 1'b1);
        cyc(1);
        expect1("R9 closed at third edge", access_en, 1'b0);
        expect1("R3 main rail kept", sel_backup, 1'b0);
        expect1("R7 abort while closed", bus_abort, 1'b1);
        expect1("R7 write dropped", wr_commit, 1'b0);
        wr = 1'b0; busy = 1'b0;

        // R2 both low
        bkp_a = 1'b1; cyc(4);
        expect1("R2 backup selected", sel_backup, 1'b1);
        expect1("R1 closed on backup", access_en, 1'b0);

        // R5 recovery with oscillator stopped
        osc = 1'b0; pf_a = 1'b0; bkp_a = 1'b0; cyc(4);
        expect1("R5 open without wait", access_en, 1'b1);
        expect1("R2 main rail again", sel_backup, 1'b0);
        osc = 1'b1;

        // R6 re-dip in the recovery window
        pf_a = 1'b1; cyc(5); pf_a = 1'b0;
        ticks(30);
        expect1("R4 closed mid window", access_en, 1'b0);
        pf_a = 1'b1; cyc(6); pf_a = 1'b0;
        ticks(60);
        expect1("R6 count restarted", access_en, 1'b0);
        ticks(12);
        expect1("R6 open after full interval", access_en, 1'b1);

        // R5 oscillator lost during recovery
        pf_a = 1'b1; cyc(5); pf_a = 1'b0;
        ticks(10);
        expect1("R4 closed early in window", access_en, 1'b0);
        osc = 1'b0; cyc(2);
        expect1("R5 open on oscillator loss", access_en, 1'b1);
        osc = 1'b1;

        // dip coinciding with recovery release and oscillator change
        pf_a = 1'b1; bkp_a = 1'b1; cyc(5);
        pf_a = 1'b0; cyc(1); osc = 1'b0; cyc(6);
        expect1("R5 open after late oscillator stop", access_en, 1'b1);
        osc = 1'b1;
        cyc(20);

        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule